// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Unit

This block combines two eight-line priority interrupt controllers into one sixteen-line source for a processor. Request lines 0 to 7 belong to the primary controller and lines 8 to 15 to the secondary controller. The secondary controller feeds the primary through primary line 2. The block drives a single interrupt level to the processor.

When the processor pulses the acknowledge strobe, the block selects the winning line. It marks that line as in service, clears an edge-latched request and returns a registered 8-bit vector with the 4-bit number of the serviced line. If no line is pending on a controller at acknowledge time, the block substitutes a spurious line 7 vector for that controller.

The vector bases, the per-line trigger mode and the automatic end-of-interrupt options are static configuration inputs.

Top module: `cascade_ack_unit`

## Requirements
- R1: `int_out` is high exactly when the primary controller holds a pending request that outranks everything in its in-service set. It is re-evaluated from the updated state in the cycle after every acknowledge.
- R2: An `ack_stb` pulse in cycle N makes `ack_valid` high in cycle N+1 only. `ack_vec` and `ack_line` hold that acknowledge's result from cycle N+1 on.
- R3: Priority is rotating. The rank of line k is (k - offset) mod 8, with offset 0 after reset, and the lowest rank wins. Without automatic end of interrupt, a line in service blocks every line of equal or lower rank on its controller.
- R4: A line whose `level_mode` bit is 0 latches its request on a rising input edge, and acknowledging that line clears the request. A line whose bit is 1 follows its input and is not cleared by acknowledge. Primary line 2 is always edge-latched.
- R5: While the secondary controller has a winning request, primary line 2 is requested. When the primary acknowledges line 2, this request is dropped and then re-raised one cycle later if the secondary still has a winner.
- R6: When the primary winner is line 2 and the secondary has a winner s, the secondary services s, `ack_vec` = {slv_base[7:3], s} and `ack_line` = s + 8.
- R7: When the primary winner is line 2 but the secondary has no winner, `ack_vec` = {slv_base[7:3], 3'd7}, `ack_line` = 15, and secondary state is unchanged.
- R8: When the primary has no winner at acknowledge, `ack_vec` = {mst_base[7:3], 3'd7}, `ack_line` = 7, and no state changes.
- R9: Vectors keep only bits [7:3] of the configured base. Bits [2:0] of `ack_vec` always equal bits [2:0] of `ack_line`.
- R10: With `auto_eoi` high, an acknowledged line is not left in service, so the next lower pending line is delivered on the next acknowledge.
- R11: With `auto_eoi` and `rotate_aeoi` both high, an acknowledge of line k sets that controller's offset to (k+1) mod 8.
- R12: After reset, `int_out`, `ack_valid`, `ack_vec` and `ack_line` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | 16 | Request inputs; 0-7 primary, 8-15 secondary |
| level_mode | input | 16 | 1 = level-triggered line, 0 = edge-triggered |
| mst_base | input | 8 | Primary vector base (bits [7:3] used) |
| slv_base | input | 8 | Secondary vector base (bits [7:3] used) |
| auto_eoi | input | 1 | Automatic end of interrupt on acknowledge |
| rotate_aeoi | input | 1 | Rotate priority on automatic end of interrupt |
| ack_stb | input | 1 | Single-cycle acknowledge strobe |
| int_out | output | 1 | Interrupt level to the processor |
| ack_valid | output | 1 | Acknowledge result valid (one cycle) |
| ack_vec | output | 8 | Delivered vector |
| ack_line | output | 4 | Serviced line number, 0 to 15 |

## Verification
The hardest state to reach from the ports is a cascade acknowledge in which the primary still has line 2 pending but the secondary has nothing left. The bench reaches it by configuring a secondary line as level-triggered and raising it long enough for the primary to latch line 2. It then drops the line, so the secondary request vanishes while the primary edge latch holds. A second hard case is rotation, which only becomes visible after a later request arrives on a line that would have won under the default order. The bench therefore raises that line after the first acknowledge, once the offset has moved.

// File: rtl/casc_pkg.sv
package casc_pkg;
  localparam int unsigned NL = 8;
  localparam int unsigned LW = $clog2(NL);
  localparam int unsigned VW = 8;

  // rank of the best set bit when rotated by off; NL means empty
  function automatic logic [LW:0] rank_of(input logic [NL-1:0] m, input logic [LW-1:0] off);
    logic [LW:0]   r;
    logic [LW-1:0] idx;
    r = (LW+1)'(NL);
    for (int p = NL - 1; p >= 0; p--) begin
      idx = LW'(p) + off;
      if (m[idx]) r = (LW+1)'(p);
    end
    return r;
  endfunction

  function automatic logic [LW-1:0] line_of(input logic [LW:0] r, input logic [LW-1:0] off);
    return r[LW-1:0] + off;
  endfunction

  function automatic logic [VW-1:0] vec_of(input logic [VW-1:0] base, input logic [LW-1:0] ln);
    return {base[VW-1:LW], ln};
  endfunction

  function automatic logic [NL-1:0] onehot(input logic [LW-1:0] ln);
    return NL'(1) << ln;
  endfunction
endpackage

// File: rtl/req_capture.sv
module req_capture import casc_pkg::*; #(
  parameter int unsigned N = NL
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] set_extra,
  input  logic [N-1:0] clr,
  output logic [N-1:0] irr
);
  logic [N-1:0] prev;
  logic [N-1:0] rise;
  logic [N-1:0] edge_next;

  assign rise      = lines & ~prev;
  assign edge_next = (irr & ~clr) | rise | set_extra;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      irr  <= '0;
    end else begin
      prev <= lines;
      irr  <= (lvl & lines) | (~lvl & edge_next);
    end
  end
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver import casc_pkg::*; (
  input  logic [NL-1:0] irr,
  input  logic [NL-1:0] isr,
  input  logic [LW-1:0] off,
  output logic          hit,
  output logic [LW-1:0] win
);
  logic [LW:0] req_rank;
  logic [LW:0] svc_rank;

  assign req_rank = rank_of(irr, off);
  assign svc_rank = rank_of(isr, off);
  assign hit      = req_rank < svc_rank;
  assign win      = line_of(req_rank, off);
endmodule

// File: rtl/svc_state.sv
module svc_state import casc_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [LW-1:0] take_line,
  input  logic          aeoi,
  input  logic          rot,
  output logic [NL-1:0] isr,
  output logic [LW-1:0] off
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr <= '0;
      off <= '0;
    end else if (take) begin
      if (aeoi) begin
        if (rot) off <= take_line + LW'(1);
      end else begin
        isr <= isr | onehot(take_line);
      end
    end
  end
endmodule

// File: rtl/cascade_ack_unit.sv
module cascade_ack_unit import casc_pkg::*; #(
  parameter int unsigned CASC_LINE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2*NL-1:0] irq_lines,
  input  logic [2*NL-1:0] level_mode,
  input  logic [VW-1:0] mst_base,
  input  logic [VW-1:0] slv_base,
  input  logic          auto_eoi,
  input  logic          rotate_aeoi,
  input  logic          ack_stb,
  output logic          int_out,
  output logic          ack_valid,
  output logic [VW-1:0] ack_vec,
  output logic [LW:0]   ack_line
);
  localparam logic [LW-1:0] CASC = LW'(CASC_LINE);
  localparam logic [LW-1:0] SPUR = LW'(NL - 1);

  // named internal events
  logic [NL-1:0] mst_irr, slv_irr, mst_isr, slv_isr;
  logic [LW-1:0] mst_off, slv_off, mst_win, slv_win;
  logic          mst_hit, slv_hit;
  logic          casc_sel, take_mst, take_slv, spur_slv, spur_mst;
  logic [NL-1:0] mst_lvl, mst_clr, slv_clr, mst_set;

  assign casc_sel = mst_win == CASC;
  assign take_mst = ack_stb && mst_hit;
  assign take_slv = take_mst && casc_sel && slv_hit;
  assign spur_slv = take_mst && casc_sel && !slv_hit;
  assign spur_mst = ack_stb && !mst_hit;

  assign mst_lvl = level_mode[NL-1:0] & ~onehot(CASC);
  assign mst_clr = take_mst ? (onehot(mst_win) & ~mst_lvl) : '0;
  assign slv_clr = take_slv ? (onehot(slv_win) & ~level_mode[2*NL-1:NL]) : '0;
  assign mst_set = (slv_hit && !(take_mst && casc_sel)) ? onehot(CASC) : '0;

  req_capture u_mreq (
    .clk(clk), .rst_n(rst_n), .lines(irq_lines[NL-1:0]), .lvl(mst_lvl),
    .set_extra(mst_set), .clr(mst_clr), .irr(mst_irr)
  );
  req_capture u_sreq (
    .clk(clk), .rst_n(rst_n), .lines(irq_lines[2*NL-1:NL]),
    .lvl(level_mode[2*NL-1:NL]), .set_extra('0), .clr(slv_clr), .irr(slv_irr)
  );

  prio_resolver u_mres (.irr(mst_irr), .isr(mst_isr), .off(mst_off), .hit(mst_hit), .win(mst_win));
  prio_resolver u_sres (.irr(slv_irr), .isr(slv_isr), .off(slv_off), .hit(slv_hit), .win(slv_win));

  svc_state u_msvc (
    .clk(clk), .rst_n(rst_n), .take(take_mst), .take_line(mst_win),
    .aeoi(auto_eoi), .rot(rotate_aeoi), .isr(mst_isr), .off(mst_off)
  );
  svc_state u_ssvc (
    .clk(clk), .rst_n(rst_n), .take(take_slv), .take_line(slv_win),
    .aeoi(auto_eoi), .rot(rotate_aeoi), .isr(slv_isr), .off(slv_off)
  );

  assign int_out = mst_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid <= 1'b0;
      ack_vec   <= '0;
      ack_line  <= '0;
    end else begin
      ack_valid <= ack_stb;
      if (ack_stb) begin
        if (spur_mst) begin
          ack_vec  <= vec_of(mst_base, SPUR);
          ack_line <= {1'b0, SPUR};
        end else if (take_slv) begin
          ack_vec  <= vec_of(slv_base, slv_win);
          ack_line <= {1'b1, slv_win};
        end else if (spur_slv) begin
          ack_vec  <= vec_of(slv_base, SPUR);
          ack_line <= {1'b1, SPUR};
        end else begin
          ack_vec  <= vec_of(mst_base, mst_win);
          ack_line <= {1'b0, mst_win};
        end
      end
    end
  end
endmodule

// File: rtl/casc_ack_chk.sv
module casc_ack_chk import casc_pkg::*; #(
  parameter int unsigned CASC_LINE = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack_stb,
  input logic          auto_eoi,
  input logic [VW-1:0] mst_base,
  input logic          mst_hit,
  input logic [LW-1:0] mst_win,
  input logic          slv_hit,
  input logic [NL-1:0] mst_isr,
  input logic [NL-1:0] slv_isr,
  input logic          ack_valid,
  input logic [VW-1:0] ack_vec,
  input logic [LW:0]   ack_line
);
  // R2
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) ack_stb |=> ack_valid);
  // R2
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !ack_stb |=> !ack_valid);
  // R8
  spur_mst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_stb && !mst_hit) |=> (ack_line == (LW+1)'(NL - 1)) && (ack_vec[VW-1:LW] == $past(mst_base[VW-1:LW])));
  // R9
  vec_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> ack_vec[LW-1:0] == ack_line[LW-1:0]);
  // R10
  aeoi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_stb && auto_eoi) |=> (mst_isr == $past(mst_isr)) && (slv_isr == $past(slv_isr)));
  // R7
  spur_slv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_stb && mst_hit && mst_win == LW'(CASC_LINE) && !slv_hit)
      |=> (ack_line == (LW+1)'(2*NL - 1)) && (slv_isr == $past(slv_isr)));
  // R3
  service_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_stb && mst_hit && !auto_eoi && mst_win != LW'(CASC_LINE)) |=> mst_isr[$past(mst_win)]);
endmodule

bind cascade_ack_unit casc_ack_chk #(.CASC_LINE(CASC_LINE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_stb(ack_stb), .auto_eoi(auto_eoi),
  .mst_base(mst_base), .mst_hit(mst_hit), .mst_win(mst_win), .slv_hit(slv_hit),
  .mst_isr(mst_isr), .slv_isr(slv_isr), .ack_valid(ack_valid),
  .ack_vec(ack_vec), .ack_line(ack_line)
);

// File: tb/sim_cascade_ack_unit.sv
module sim_cascade_ack_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_lines = '0;
  logic [15:0] level_mode = '0;
  logic [7:0]  mst_base = 8'h27;
  logic [7:0]  slv_base = 8'h75;
  logic        auto_eoi = 1'b0;
  logic        rotate_aeoi = 1'b0;
  logic        ack_stb = 1'b0;
  logic        int_out, ack_valid;
  logic [7:0]  ack_vec;
  logic [3:0]  ack_line;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  cascade_ack_unit u0 (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .level_mode(level_mode),
    .mst_base(mst_base), .slv_base(slv_base), .auto_eoi(auto_eoi),
    .rotate_aeoi(rotate_aeoi), .ack_stb(ack_stb), .int_out(int_out),
    .ack_valid(ack_valid), .ack_vec(ack_vec), .ack_line(ack_line)
  );

  // {lines, expected int (4b), expected vector, expected line}
  localparam logic [31:0] TBL [6] = '{
    {16'h0020, 4'h1, 8'h25, 4'h5},   // R3 R9 single primary line, base masked
    {16'h0048, 4'h1, 8'h23, 4'h3},   // R3 lower line wins
    {16'h0201, 4'h1, 8'h20, 4'h0},   // R3 primary 0 outranks cascade
    {16'h1010, 4'h1, 8'h74, 4'hC},   // R5 R6 cascade beats primary 4
    {16'h4200, 4'h1, 8'h71, 4'h9},   // R6 secondary priority
    {16'h0000, 4'h0, 8'h27, 4'h7}    // R8 spurious primary
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reset_dut();
    rst_n = 1'b0; irq_lines = '0; ack_stb = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic ack_expect(input string tag, input logic [7:0] ev, input logic [3:0] el);
    ack_stb = 1'b1;
    tick(1);
    ack_stb = 1'b0;
    check({tag, " R2 valid"}, 16'(ack_valid), 16'h1);
    check({tag, " vector"}, 16'(ack_vec), 16'(ev));
    check({tag, " line"}, 16'(ack_line), 16'(el));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R12 reset state
    tick(1);
    check("R12 int", 16'(int_out), 16'h0);
    check("R12 valid", 16'(ack_valid), 16'h0);
    check("R12 vec", 16'(ack_vec), 16'h0);
    check("R12 line", 16'(ack_line), 16'h0);
    reset_dut();

    foreach (TBL[i]) begin
      reset_dut();
      irq_lines = TBL[i][31:16];
      tick(3);
      check("R1 table int", 16'(int_out), 16'(TBL[i][15:12]));
      ack_expect("R3 R6 R8 table", TBL[i][11:4], TBL[i][3:0]);
    end

    // R1 R2 R4: edge request cleared, int re-evaluated, strobe gives single valid
    reset_dut();
    irq_lines = 16'h0020;
    tick(3);
    ack_expect("R4 edge first", 8'h25, 4'h5);
    check("R1 int after ack", 16'(int_out), 16'h0);
    tick(1);
    check("R2 valid drops", 16'(ack_valid), 16'h0);
    ack_expect("R4 edge cleared", 8'h27, 4'h7);

    // R3 in-service blocks lower line
    reset_dut();
    irq_lines = 16'h0028;
    tick(3);
    ack_expect("R3 nested first", 8'h23, 4'h3);
    ack_expect("R3 lower blocked", 8'h27, 4'h7);

    // R10 automatic end of interrupt
    auto_eoi = 1'b1;
    reset_dut();
    irq_lines = 16'h0028;
    tick(3);
    ack_expect("R10 first", 8'h23, 4'h3);
    ack_expect("R10 next delivered", 8'h25, 4'h5);

    // R4 level mode keeps request
    level_mode = 16'h0020;
    reset_dut();
    irq_lines = 16'h0020;
    tick(3);
    ack_expect("R4 level first", 8'h25, 4'h5);
    ack_expect("R4 level kept", 8'h25, 4'h5);
    irq_lines = '0;
    tick(2);
    check("R4 level follows input", 16'(int_out), 16'h0);
    level_mode = '0;

    // R11 rotation
    rotate_aeoi = 1'b1;
    reset_dut();
    irq_lines = 16'h0028;
    tick(3);
    ack_expect("R11 first", 8'h23, 4'h3);
    irq_lines = 16'h002A;
    tick(3);
    ack_expect("R11 rotated order", 8'h25, 4'h5);
    ack_expect("R11 wrap", 8'h21, 4'h1);
    rotate_aeoi = 1'b0;

    // R5 R6 cascade re-raise after acknowledge
    reset_dut();
    irq_lines = 16'h4200;
    tick(3);
    ack_expect("R6 first", 8'h71, 4'h9);
    tick(3);
    check("R5 cascade re-raised", 16'(int_out), 16'h1);
    ack_expect("R6 second", 8'h76, 4'hE);
    tick(3);
    check("R1 idle after cascade", 16'(int_out), 16'h0);

    // R7 spurious secondary
    auto_eoi = 1'b0;
    level_mode = 16'h0100;
    reset_dut();
    irq_lines = 16'h0100;
    tick(3);
    irq_lines = '0;
    tick(3);
    check("R5 line 2 latched", 16'(int_out), 16'h1);
    ack_expect("R7 spurious secondary", 8'h77, 4'hF);
    level_mode = '0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule